// File: doc/BRIEF.md
# Protection FET drive controller

This block produces the logic-level gate commands for the three protection switches of a battery pack: the charge switch, the discharge switch and the pre-charge switch. A host writes a 3-bit switch code, tagged with a 3-bit target address, through a load strobe. When the address names the switch-control register, the code is latched. Each output is the inverse of one bit of the latched code, so a cleared bit drives its output high.

Two direct pins from the host microcontroller override the latched code. The discharge override forces the discharge output high. The charge override forces both the charge and the pre-charge outputs high. A power-down flag forces all three outputs high, which stops discharge. All of this forcing is combinational. Releasing a pin therefore shows the latched code again at once, even if that code changed while the pin was held.

Top module: `fet_gate_ctrl`

## Requirements
- R1: With no override and no power-down, charge_gate = NOT code[2], disch_gate = NOT code[1] and prech_gate = NOT code[0] of the latched code. For example, code 011 drives only charge high, 100 drives only charge low, 101 drives only discharge high and 110 drives only pre-charge high.
- R2: Code 000 drives all three outputs high. Code 111 drives all three outputs low.
- R3: While rst_n is low, and after any reset, the latched code is 000 and all three outputs are high.
- R4: While disch_force is high, disch_gate is high whatever the latched code.
- R5: While charge_force is high, charge_gate and prech_gate are both high whatever the latched code.
- R6: A load accepted while an override is high updates the latched code, but the forced outputs stay high until the override is released.
- R7: While power_down is high, all three outputs are high.
- R8: When an override or power_down is released, the outputs show the latched code in the same cycle, with no clock edge needed.
- R9: A load strobe whose address is not FET_ADDR (default 3'b010) leaves the latched code and the outputs unchanged.
- R10: A load strobe with address FET_ADDR is taken on the rising clock edge where cmd_load is high. The new output levels appear right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_load | input | 1 | Load strobe for one address/code pair |
| cmd_addr | input | 3 | Target register address |
| cmd_code | input | 3 | Switch code: bit 2 charge, bit 1 discharge, bit 0 pre-charge |
| disch_force | input | 1 | Override: forces the discharge output high |
| charge_force | input | 1 | Override: forces the charge and pre-charge outputs high |
| power_down | input | 1 | Forces all outputs high |
| charge_gate | output | 1 | Charge switch command |
| disch_gate | output | 1 | Discharge switch command |
| prech_gate | output | 1 | Pre-charge switch command |

## Verification
All eight codes are loaded in turn, one after another. This shows that each output follows its own bit with the correct inversion, and that no two bits are swapped.

Loads to every other address, each carrying a code that would change the outputs, show that the address decode filters them.

Each override is then held over a latched all-low code while new codes are loaded. Releasing the override in the middle of a cycle separates four things:
- that the forcing is combinational;
- that each pin covers the right outputs;
- that a load made under an override still takes effect;
- that the release shows the latched code without waiting for a clock edge.

Power-down and a reset in the middle of the run are checked the same way.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  localparam int GATE_N = 3;
  // bit index of each switch in the code
  localparam int IDX_CHG = 2;
  localparam int IDX_DIS = 1;
  localparam int IDX_PRE = 0;

  typedef logic [GATE_N-1:0] gate_vec_t;

  // which outputs each force source covers
  localparam gate_vec_t CHG_FORCE_MASK = gate_vec_t'((1 << IDX_CHG) | (1 << IDX_PRE));
  localparam gate_vec_t DIS_FORCE_MASK = gate_vec_t'(1 << IDX_DIS);
endpackage

// File: rtl/fgc_rst_sync.sv
module fgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fgc_cmd_reg.sv
module fgc_cmd_reg #(
  parameter int          ADDR_W   = 3,
  parameter int          CODE_W   = 3,
  parameter logic [ADDR_W-1:0] FET_ADDR = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_sync_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CODE_W-1:0] cmd_code,
  output logic [CODE_W-1:0] cmd_q
);
  logic              cmd_en;
  logic [CODE_W-1:0] cmd_d;

  always_comb begin
    cmd_en = cmd_load && (cmd_addr == FET_ADDR) && rst_sync_n;
    cmd_d  = cmd_en ? cmd_code : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cmd_q <= '0;
    else if (!rst_sync_n) cmd_q <= '0;
    else                  cmd_q <= cmd_d;
  end
endmodule

// File: rtl/fgc_gate_mux.sv
module fgc_gate_mux
  import fgc_pkg::*;
(
  input  gate_vec_t cmd_q,
  input  logic      disch_force,
  input  logic      charge_force,
  input  logic      power_down,
  output gate_vec_t gate
);
  gate_vec_t force_vec;

  always_comb begin
    force_vec = ({GATE_N{charge_force}} & CHG_FORCE_MASK)
              | ({GATE_N{disch_force}}  & DIS_FORCE_MASK)
              | {GATE_N{power_down}};
  end

  for (genvar g = 0; g < GATE_N; g++) begin : g_bit
    assign gate[g] = force_vec[g] | ~cmd_q[g];
  end
endmodule

// File: rtl/fet_gate_ctrl.sv
module fet_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int          ADDR_W      = 3,
  parameter logic [ADDR_W-1:0] FET_ADDR = 3'b010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [GATE_N-1:0] cmd_code,
  input  logic              disch_force,
  input  logic              charge_force,
  input  logic              power_down,
  output logic              charge_gate,
  output logic              disch_gate,
  output logic              prech_gate
);
  logic      rst_sync_n;
  gate_vec_t cmd_q;
  gate_vec_t gate;

  fgc_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fgc_cmd_reg #(.ADDR_W(ADDR_W), .CODE_W(GATE_N), .FET_ADDR(FET_ADDR)) i_cmd_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .cmd_load   (cmd_load),
    .cmd_addr   (cmd_addr),
    .cmd_code   (cmd_code),
    .cmd_q      (cmd_q)
  );

  fgc_gate_mux i_gate_mux (
    .cmd_q        (cmd_q),
    .disch_force  (disch_force),
    .charge_force (charge_force),
    .power_down   (power_down),
    .gate         (gate)
  );

  assign charge_gate = gate[IDX_CHG];
  assign disch_gate  = gate[IDX_DIS];
  assign prech_gate  = gate[IDX_PRE];
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int          ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] FET_ADDR = 3'b010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_load,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [2:0]        cmd_q,
  input logic              disch_force,
  input logic              charge_force,
  input logic              power_down,
  input logic              charge_gate,
  input logic              disch_gate,
  input logic              prech_gate
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_high_r3: assert (charge_gate && disch_gate && prech_gate)
        else $error("reset outputs not all high");
    end
  end

  p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!disch_force && !charge_force && !power_down) |->
      ({charge_gate, disch_gate, prech_gate} == ~cmd_q));

  p_dis_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disch_force |-> disch_gate);

  p_chg_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    charge_force |-> (charge_gate && prech_gate));

  p_pdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (charge_gate && disch_gate && prech_gate));

  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_load && cmd_addr == FET_ADDR)) ##1
      ($stable(disch_force) && $stable(charge_force) && $stable(power_down))
      |-> $stable({charge_gate, disch_gate, prech_gate}));
endmodule

bind fet_gate_ctrl fgc_checker #(.ADDR_W(ADDR_W), .FET_ADDR(FET_ADDR)) i_fgc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_load     (cmd_load),
  .cmd_addr     (cmd_addr),
  .cmd_q        (cmd_q),
  .disch_force  (disch_force),
  .charge_force (charge_force),
  .power_down   (power_down),
  .charge_gate  (charge_gate),
  .disch_gate   (disch_gate),
  .prech_gate   (prech_gate)
);

// File: tb/test_fet_gate_ctrl.sv
`timescale 1ns/1ps
module test_fet_gate_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_load;
  logic [2:0] cmd_addr;
  logic [2:0] cmd_code;
  logic       disch_force, charge_force, power_down;
  logic       charge_gate, disch_gate, prech_gate;

  int    total = 0;
  int    bad   = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R3";
  int    m_cmd = 0;

  always #4 clk = ~clk;

  fet_gate_ctrl i_fet_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .disch_force(disch_force), .charge_force(charge_force),
    .power_down(power_down), .charge_gate(charge_gate), .disch_gate(disch_gate),
    .prech_gate(prech_gate)
  );

  // behavioural reference: latched code
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_cmd = 0;
    else if (cmd_load && cmd_addr == 3'd2) m_cmd = int'(cmd_code);
  end

  function automatic logic [2:0] expect_gates();
    logic c, d, p;
    c = power_down || charge_force || ((m_cmd & 4) == 0);
    d = power_down || disch_force  || ((m_cmd & 2) == 0);
    p = power_down || charge_force || ((m_cmd & 1) == 0);
    return {c, d, p};
  endfunction

  task automatic check_now(string req);
    logic [2:0] exp_v, act_v;
    exp_v = expect_gates();
    act_v = {charge_gate, disch_gate, prech_gate};
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s t=%0t gates actual=%b expected=%b", req, $time, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (!done) check_now(cur_req);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(bit ld, logic [2:0] a, logic [2:0] c);
    @(posedge clk); #2;
    cmd_load = ld; cmd_addr = a; cmd_code = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 3'd0);
  endtask

  initial begin
    rst_n = 0; cmd_load = 0; cmd_addr = 0; cmd_code = 0;
    disch_force = 0; charge_force = 0; power_down = 0;
    cur_req = "R3";
    idle(3);
    // load attempt during reset must be ignored
    step(1, 3'd2, 3'd7);
    step(0, 3'd0, 3'd0);
    @(posedge clk); #2 rst_n = 1;
    idle(4);

    // all eight codes: R1 mapping, R2 extremes, R10 timing
    for (int k = 0; k < 8; k++) begin
      cur_req = (k == 0 || k == 7) ? "R2" : "R1";
      step(1, 3'd2, 3'(k));
      cur_req = "R10";
      step(0, 3'd0, 3'd0);
      idle(1);
    end
    // back-to-back loads
    cur_req = "R10";
    step(1, 3'd2, 3'd3); step(1, 3'd2, 3'd4); step(1, 3'd2, 3'd5);
    step(1, 3'd2, 3'd6); idle(2);

    // R9: other addresses ignored
    step(1, 3'd2, 3'd7); idle(1);
    cur_req = "R9";
    for (int a = 0; a < 8; a++) if (a != 2) begin
      step(1, 3'(a), 3'd0);
      step(0, 3'd0, 3'd0);
    end
    idle(2);

    // R4 / R6 / R8 on discharge override
    cur_req = "R4";
    step(0, 3'd0, 3'd0); #1 disch_force = 1;
    idle(2);
    cur_req = "R6";
    step(1, 3'd2, 3'd5); step(0, 3'd0, 3'd0);
    step(1, 3'd2, 3'd7); idle(2);
    cur_req = "R8";
    @(negedge clk); #1 disch_force = 0;
    #1 check_now("R8");
    idle(2);

    // R5 / R6 / R8 on charge override
    cur_req = "R5";
    @(negedge clk); #1 charge_force = 1;
    #1 check_now("R5");
    idle(2);
    cur_req = "R6";
    step(1, 3'd2, 3'd2); idle(1);
    step(1, 3'd2, 3'd7); idle(2);
    cur_req = "R8";
    @(negedge clk); #1 charge_force = 0;
    #1 check_now("R8");
    idle(2);

    // both overrides together
    cur_req = "R5";
    step(0, 3'd0, 3'd0); disch_force = 1; charge_force = 1; idle(2);
    step(0, 3'd0, 3'd0); disch_force = 0; charge_force = 0; idle(2);

    // R7 power-down
    cur_req = "R7";
    @(negedge clk); #1 power_down = 1;
    #1 check_now("R7");
    step(1, 3'd2, 3'd7); idle(2);
    cur_req = "R8";
    @(negedge clk); #1 power_down = 0;
    #1 check_now("R8");
    idle(2);

    // R3 mid-run reset
    cur_req = "R3";
    @(negedge clk); #1 rst_n = 0;
    #1 check_now("R3");
    idle(2);
    @(posedge clk); #2 rst_n = 1;
    idle(4);
    cur_req = "R1";
    step(1, 3'd2, 3'd1); idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule